// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator and Character Format Decoder

This block serves one channel of a serial controller. Software programs a 16-bit time constant as two byte registers and sets a clock-mode multiplier in a mode register. From these the block makes a one-clock enable pulse at the programmed bit-rate. The shifter that consumes the pulse is not part of this block. The channel reference runs at half the system clock. Each base period lasts the time constant plus two reference periods. The base period is then stretched by a factor of 1, 16, 32 or 64.

The block also holds the character-format fields and decodes them into plain control signals for the shifter: parity enable, parity sense, stop-bit count and data length. The data-length field does not use a monotonic code. The time constant is returned on a read-back port. Any write to one of the four owned registers restarts the divider from zero with the new settings. Writes to any other register number leave the block untouched.

Top module: `bdg_rate_gen`

## Requirements
- R1: With clock mode x1, the tick period is 2*(TC+2) system clocks, because the reference runs at half the system clock.
- R2: TC is formed from register 12 as the low byte and register 13 as the high byte. The general period is 2*(TC+2)*M system clocks.
- R3: Register 4 bits 7:6 select M: 00 gives 1, 01 gives 16, 10 gives 32 and 11 gives 64.
- R4: Register 4 bit 0 drives `par_en`. Register 4 bit 1 drives `par_even` (1 means even, 0 means odd).
- R5: `two_stop` is 1 only when register 4 bits 3:2 equal 11. Every other value of that field means one stop bit.
- R6: Register 5 bits 6:5 set `data_bits` as follows: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8.
- R7: `tconst_rd` shows {register 13, register 12} from the cycle after the write edge.
- R8: After synchronous reset, register 4 decodes as x1 with one stop bit and no parity, `data_bits` is 5 and TC is 0. The first tick then comes 4 clocks after the last reset edge.
- R9: A write to register 4, 5, 12 or 13 restarts the divider. The next tick comes exactly P clocks after the write edge, where P is computed from the new values. No tick is shown in the cycle after the write.
- R10: A write to any other register number does not change the tick timing, the format outputs or `tconst_rd`.
- R11: `rate_tick` is high for exactly one clock in each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W (4) | Register number being written |
| cfg_wdata | input | 8 | Write data byte |
| rate_tick | output | 1 | One-clock bit-rate enable pulse |
| par_en | output | 1 | Parity enabled |
| par_even | output | 1 | Even parity selected |
| two_stop | output | 1 | Two stop bits selected |
| data_bits | output | 4 | Data length (5 to 8) |
| tconst_rd | output | 16 | Time-constant read-back |

## Verification
The tick is registered. It therefore appears after the P-th rising edge counted from the restart edge (the write edge or the last reset edge), and again after every further P edges. The format outputs and the read-back come straight from registers and change one clock after the write edge. The bench drives and samples on the falling edge. It advances a behavioural edge counter at every rising edge and compares all outputs at the following falling edge, so each expected value is placed exactly where the register chain puts it.

// File: rtl/bdg_pkg.sv
// Shared definitions for the bit-rate tick generator.
// Register numbers are the ones decoded by neighbouring channel logic.
package bdg_pkg;

    localparam int REG_W        = 8;
    localparam int TC_BYTES     = 2;
    localparam int MUL_W        = 6;

    localparam int REG_MODE_IDX = 4;
    localparam int REG_FMT_IDX  = 5;
    localparam int REG_TC_IDX   = 12;   // low byte; high byte at next number

    typedef enum logic [1:0] {
        CM_X1  = 2'b00,
        CM_X16 = 2'b01,
        CM_X32 = 2'b10,
        CM_X64 = 2'b11
    } clk_mode_e;

    typedef struct packed {
        clk_mode_e  clk_mode;
        logic [1:0] stop;
        logic       par_even;
        logic       par_en;
    } mode_t;

    localparam mode_t MODE_RST = '{clk_mode: CM_X1, stop: 2'b01,
                                   par_even: 1'b0, par_en: 1'b0};

endpackage

// File: rtl/bdg_regs.sv
// Holds the mode fields, the data-length field and the time-constant bytes.
// Assumes one byte write per cycle; flags a restart for any owned register.
module bdg_regs
    import bdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int TC_W  = REG_W * TC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output mode_t             mode_q,
    output logic [1:0]        len_q,
    output logic [TC_W-1:0]   tc_q,
    output logic              reload
);

    logic hit_mode;
    logic hit_fmt;
    logic [TC_BYTES-1:0] hit_tc;

    assign hit_mode = cfg_we && (cfg_addr == ADDR_W'(REG_MODE_IDX));
    assign hit_fmt  = cfg_we && (cfg_addr == ADDR_W'(REG_FMT_IDX));
    assign reload   = hit_mode || hit_fmt || (|hit_tc);

    // Mode and length fields: load on matching write, defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            len_q  <= 2'b00;
        end else begin
            if (hit_mode) begin
                mode_q <= '{clk_mode: clk_mode_e'(cfg_wdata[7:6]),
                            stop:     cfg_wdata[3:2],
                            par_even: cfg_wdata[1],
                            par_en:   cfg_wdata[0]};
            end
            if (hit_fmt) begin
                len_q <= cfg_wdata[6:5];
            end
        end
    end

    // One byte lane of the time constant per consecutive register number.
    for (genvar b = 0; b < TC_BYTES; b++) begin : g_tc
        assign hit_tc[b] = cfg_we && (cfg_addr == ADDR_W'(REG_TC_IDX + b));

        // Byte lane storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tc_q[b*REG_W +: REG_W] <= '0;
            end else if (hit_tc[b]) begin
                tc_q[b*REG_W +: REG_W] <= cfg_wdata;
            end
        end

        a_r7_byte_readback: assert property (@(posedge clk) disable iff (!rst_n)
            hit_tc[b] |=> (tc_q[b*REG_W +: REG_W] == $past(cfg_wdata)));
    end

    a_r8_mode_default: assert property (@(posedge clk)
        !rst_n |=> (mode_q == MODE_RST && len_q == 2'b00 && tc_q == '0));

    a_r10_foreign_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !reload) |=> ($stable(mode_q) && $stable(len_q) && $stable(tc_q)));

endmodule

// File: rtl/bdg_fmt_dec.sv
// Turns the stored mode and length fields into shifter controls and the
// clock-mode multiplier terminal count. Purely combinational.
module bdg_fmt_dec
    import bdg_pkg::*;
(
    input  mode_t            mode_q,
    input  logic [1:0]       len_q,
    output logic             par_en,
    output logic             par_even,
    output logic             two_stop,
    output logic [3:0]       data_bits,
    output logic [MUL_W-1:0] mul_last
);

    // Parity and stop-bit decode.
    always_comb begin
        par_en   = mode_q.par_en;
        par_even = mode_q.par_even;
        two_stop = (mode_q.stop == 2'b11);
    end

    // Data length: the field code is not in numeric order.
    always_comb begin
        case (len_q)
            2'b00:   data_bits = 4'd5;
            2'b01:   data_bits = 4'd7;
            2'b10:   data_bits = 4'd6;
            default: data_bits = 4'd8;
        endcase
    end

    // Multiplier terminal count (multiplier minus one).
    always_comb begin
        case (mode_q.clk_mode)
            CM_X1:   mul_last = MUL_W'(0);
            CM_X16:  mul_last = MUL_W'(15);
            CM_X32:  mul_last = MUL_W'(31);
            default: mul_last = MUL_W'(63);
        endcase
    end

endmodule

// File: rtl/bdg_divider.sv
// Three-stage divider: a half-rate phase bit, a base counter spanning TC+2
// reference periods, and a multiplier counter. Emits a registered one-clock
// tick on the last state of the period. Assumes tc and mul_last only change
// together with reload.
module bdg_divider
    import bdg_pkg::*;
#(
    parameter int TC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [TC_W-1:0]  tc,
    input  logic [MUL_W-1:0] mul_last,
    output logic             rate_tick
);

    logic              ph_q;
    logic [TC_W:0]     base_q;
    logic [MUL_W-1:0]  mul_q;
    logic              tick_q;
    logic [TC_W:0]     base_end;
    logic              base_wrap;
    logic              period_end;

    assign base_end   = {1'b0, tc} + 1'b1;
    assign base_wrap  = ph_q && (base_q == base_end);
    assign period_end = base_wrap && (mul_q == mul_last);
    assign rate_tick  = tick_q;

    // Advance the counter chain; reset or reload restarts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            ph_q   <= 1'b0;
            base_q <= '0;
            mul_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            ph_q   <= ~ph_q;
            tick_q <= period_end;
            if (ph_q) begin
                base_q <= base_wrap ? '0 : base_q + 1'b1;
            end
            if (base_wrap) begin
                mul_q <= period_end ? '0 : mul_q + 1'b1;
            end
        end
    end

    a_r11_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        rate_tick |=> !rate_tick);

    a_r9_reload_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !rate_tick);

    a_r2_base_bound: assert property (@(posedge clk) disable iff (!rst_n)
        base_q <= base_end);

    a_r3_mul_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mul_q <= mul_last);

endmodule

// File: rtl/bdg_rate_gen.sv
// Top level: per-channel bit-rate tick generator with format decode.
// Assumes a single write port shared with the rest of the channel registers;
// register numbers outside 4, 5, 12 and 13 are ignored here.
module bdg_rate_gen
    import bdg_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int TC_W  = REG_W * TC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic              rate_tick,
    output logic              par_en,
    output logic              par_even,
    output logic              two_stop,
    output logic [3:0]        data_bits,
    output logic [TC_W-1:0]   tconst_rd
);

    mode_t            mode_q;
    logic [1:0]       len_q;
    logic [TC_W-1:0]  tc_q;
    logic             reload;
    logic [MUL_W-1:0] mul_last;

    bdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_q    (mode_q),
        .len_q     (len_q),
        .tc_q      (tc_q),
        .reload    (reload)
    );

    bdg_fmt_dec u_dec (
        .mode_q    (mode_q),
        .len_q     (len_q),
        .par_en    (par_en),
        .par_even  (par_even),
        .two_stop  (two_stop),
        .data_bits (data_bits),
        .mul_last  (mul_last)
    );

    bdg_divider #(.TC_W(TC_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .tc        (tc_q),
        .mul_last  (mul_last),
        .rate_tick (rate_tick)
    );

    assign tconst_rd = tc_q;

endmodule

// File: tb/tb_bdg_rate_gen.sv
`timescale 1ns/1ps
module tb_bdg_rate_gen;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        rate_tick;
    logic        par_en;
    logic        par_even;
    logic        two_stop;
    logic [3:0]  data_bits;
    logic [15:0] tconst_rd;

    always #4 clk = ~clk;

    bdg_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rate_tick(rate_tick), .par_en(par_en),
        .par_even(par_even), .two_stop(two_stop), .data_bits(data_bits),
        .tconst_rd(tconst_rd)
    );

    int      checks = 0;
    int      failures = 0;
    int      wd = 0;
    string   tag = "R8";
    logic [7:0] m_r4, m_r5, m_r12, m_r13;
    longint  cnt = 0;
    logic    exp_tick = 1'b0;
    logic    prev_tick = 1'b0;

    function automatic int period();
        int m;
        case (m_r4[7:6])
            2'b00: m = 1;
            2'b01: m = 16;
            2'b10: m = 32;
            default: m = 64;
        endcase
        return 2 * (int'({m_r13, m_r12}) + 2) * m;
    endfunction

    function automatic int exp_len();
        case (m_r5[6:5])
            2'b00: return 5;
            2'b01: return 7;
            2'b10: return 6;
            default: return 8;
        endcase
    endfunction

    task automatic check(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // One clock: drive, let the edge happen, update model, compare.
    task automatic cyc(logic rst, logic we, logic [3:0] a, logic [7:0] d);
        rst_n = rst; cfg_we = we; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        if (!rst) begin
            m_r4 = 8'h04; m_r5 = 8'h00; m_r12 = 8'h00; m_r13 = 8'h00;
            cnt = 0; exp_tick = 1'b0;
        end else if (we && (a == 4 || a == 5 || a == 12 || a == 13)) begin
            case (a)
                4'd4:  m_r4  = d;
                4'd5:  m_r5  = d;
                4'd12: m_r12 = d;
                default: m_r13 = d;
            endcase
            cnt = 0; exp_tick = 1'b0;
        end else begin
            cnt++;
            exp_tick = ((cnt % longint'(period())) == 0);
        end
        @(negedge clk);
        check(tag, "rate_tick", int'(rate_tick), int'(exp_tick));
        if (prev_tick) check("R11", "tick after tick", int'(rate_tick), 0);
        check("R4", "par_en", int'(par_en), int'(m_r4[0]));
        check("R4", "par_even", int'(par_even), int'(m_r4[1]));
        check("R5", "two_stop", int'(two_stop), int'(m_r4[3:2] == 2'b11));
        check("R6", "data_bits", int'(data_bits), exp_len());
        check("R7", "tconst_rd", int'(tconst_rd), int'({m_r13, m_r12}));
        prev_tick = rate_tick;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 4'd0, 8'h00);
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            failures++;
            $display("FAIL watchdog run length actual=%0d expected<=150000", wd);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        // R8: reset defaults and first ticks at period 4
        tag = "R8";
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 4'd0, 8'h00);
        idle(13);
        // R10: foreign register numbers leave everything alone
        tag = "R10";
        wr(4'd3, 8'hFF);
        idle(2);
        wr(4'd9, 8'hC0);
        wr(4'd0, 8'h3F);
        wr(4'd14, 8'h55);
        idle(9);
        // R1: x1 with TC=3 -> period 10
        tag = "R1";
        wr(4'd12, 8'h03);
        idle(23);
        // R9: rewrite mid-period restarts the count
        tag = "R9";
        wr(4'd12, 8'h03);
        idle(25);
        // R3: multiplier 16, 32, 64 with format fields varied (R4, R5)
        tag = "R3";
        wr(4'd4, 8'h40);
        idle(330);
        wr(4'd4, 8'h8B);
        idle(650);
        wr(4'd4, 8'hCD);
        idle(1290);
        wr(4'd4, 8'h09);
        idle(12);
        // R6: data-length codes, each write also restarts
        tag = "R6";
        wr(4'd5, 8'h20); idle(4);
        wr(4'd5, 8'h40); idle(4);
        wr(4'd5, 8'h60); idle(4);
        wr(4'd5, 8'h9F); idle(4);
        // R2: high byte from register 13, TC=0x0100 -> period 516
        tag = "R2";
        wr(4'd4, 8'h04);
        wr(4'd13, 8'h01);
        wr(4'd12, 8'h00);
        idle(1040);
        // R8: a second reset restores defaults
        tag = "R8";
        cyc(1'b0, 1'b0, 4'd0, 8'h00);
        idle(9);
        summary();
        $finish;
    end

endmodule